// File: doc/BRIEF.md
# Remote DMA Data Port

This block lets a host move bytes to and from a local packet memory through one data port, without addressing each byte itself. The host loads a 16-bit start address and a 16-bit byte count one byte at a time, picks an 8-bit or a 16-bit access width, and then strobes the data port for each read or write. Every access goes out on a word-wide local memory port with byte enables. Afterwards the address moves forward by the access width and the count goes down by the same amount. When the count runs out, a sticky completion flag is raised.

The address pointer follows a receive ring. When an increment lands exactly on the ring stop page, the pointer reloads with the ring start page. Only two address ranges reach memory: the 32-byte identity area at the bottom, and a 32 KiB window above 16 KiB. Writes outside these ranges are dropped, and reads outside them return all ones. A 16-bit access ignores address bit 0 and uses little-endian lanes. Read data appears two clock edges after the read strobe and comes with a one-cycle valid pulse.

Top module: `rdma_port`

## Requirements
- R1: After reset, cur_addr and remain are 0, and done_flag and port_rdata_valid are 0.
- R2: A register write with reg_sel 0 or 1 loads the low or high byte of the address. A write with reg_sel 2 or 3 loads the low or high byte of the count. The other byte keeps its value.
- R3: With wide_en=1 an access is 16 bits, uses the address with bit 0 cleared, and takes the byte at the even address on bits 7:0 and the next byte on bits 15:8. With wide_en=0 an access is one byte and a read returns it on bits 7:0 with bits 15:8 zero. The address advances by 2 or 1.
- R4: If the advanced address equals ring_stop_pg×256, it becomes ring_start_pg×256. An advance that steps past that value without equalling it does not wrap.
- R5: If remain is at most the access width, an access sets remain to 0 and sets done_flag. Otherwise remain drops by the width.
- R6: A data-port write while remain is 0 has no effect: memory, address, count and done_flag are unchanged.
- R7: A data-port read while remain is 0 is still performed. It returns data, advances the address and sets done_flag.
- R8: Memory is reachable only at effective addresses 0–31 and 16384–49151. Writes elsewhere are not issued. Reads elsewhere return 16'hFFFF when wide and 16'h00FF when narrow.
- R9: A cmd_go pulse sets done_flag when remain is 0 and has no effect otherwise.
- R10: done_flag holds until a done_clr pulse. A completion in the same cycle as done_clr wins.
- R11: Read data is valid two rising edges after the edge that samples port_rd, marked by port_rdata_valid high for exactly that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register byte write strobe |
| reg_sel | input | 2 | 0 addr low, 1 addr high, 2 count low, 3 count high |
| reg_wdata | input | 8 | Register byte value |
| wide_en | input | 1 | 1 selects 16-bit accesses |
| ring_start_pg | input | 8 | Ring first page |
| ring_stop_pg | input | 8 | Ring page one past the end |
| cmd_go | input | 1 | Remote read/write command issued |
| done_clr | input | 1 | Clears done_flag |
| port_wr | input | 1 | Data-port write strobe |
| port_rd | input | 1 | Data-port read strobe |
| port_wdata | input | 16 | Data-port write data |
| port_rdata | output | 16 | Data-port read data |
| port_rdata_valid | output | 1 | Read data valid pulse |
| done_flag | output | 1 | Remote transfer complete status |
| cur_addr | output | 16 | Current byte address |
| remain | output | 16 | Remaining byte count |
| mem_en | output | 1 | Local memory access enable |
| mem_we | output | 1 | Local memory write enable |
| mem_be | output | 2 | Byte lane enables |
| mem_addr | output | 15 | Local memory word address |
| mem_wdata | output | 16 | Local memory write data |
| mem_rdata | input | 16 | Local memory read data, one cycle after mem_en |

## Verification
The assertions assume that port_rd and port_wr are never high in the same cycle. They also assume that no register byte write coincides with a data-port access, and that the local memory answers one cycle after mem_en. The stimulus drives one operation at a time, with each strobe lasting a single cycle. Random addresses are drawn from regions next to the ring stop page and next to every window edge, and counts are kept small, so wraps, window crossings and count exhaustion happen often.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR_LO = 2'd0,
    SEL_ADDR_HI = 2'd1,
    SEL_CNT_LO  = 2'd2,
    SEL_CNT_HI  = 2'd3
  } rdma_reg_e;
endpackage

// File: rtl/rdma_split_reg.sv
module rdma_split_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_lo,
  input  logic         load_hi,
  input  logic [7:0]   byte_in,
  input  logic         upd_en,
  input  logic [W-1:0] upd_val,
  output logic [W-1:0] q
);
  localparam int HI_W = W - 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load_lo || load_hi) begin
      if (load_lo) q[7:0]   <= byte_in;
      if (load_hi) q[W-1:8] <= HI_W'(byte_in);
    end else if (upd_en) begin
      q <= upd_val;
    end
  end

  AST_KEEP_HI_BYTE: assert property (@(posedge clk) disable iff (rst)
    load_lo && !load_hi |=> q[W-1:8] == $past(q[W-1:8])); // R2
  AST_KEEP_LO_BYTE: assert property (@(posedge clk) disable iff (rst)
    load_hi && !load_lo |=> q[7:0] == $past(q[7:0])); // R2
endmodule

// File: rtl/rdma_addr_step.sv
module rdma_addr_step #(
  parameter int ADDR_W     = 16,
  parameter int PROM_BYTES = 32,
  parameter int WIN_LO     = 16384,
  parameter int WIN_HI     = 49152
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  input  logic [ADDR_W-9:0] start_pg,
  input  logic [ADDR_W-9:0] stop_pg,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] next_addr,
  output logic              in_win
);
  logic [ADDR_W-1:0] bumped;
  logic [31:0]       eff32;

  always_comb begin
    eff_addr = wide ? {addr[ADDR_W-1:1], 1'b0} : addr;
    eff32    = 32'(eff_addr);
    in_win   = (eff32 < 32'(PROM_BYTES)) ||
               ((eff32 >= 32'(WIN_LO)) && (eff32 < 32'(WIN_HI)));
    bumped   = addr + ADDR_W'(wide) + ADDR_W'(1);
    next_addr = (bumped == {stop_pg, 8'h00}) ? {start_pg, 8'h00} : bumped;
  end
endmodule

// File: rtl/rdma_count_step.sv
module rdma_count_step #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             wide,
  output logic [CNT_W-1:0] next_cnt,
  output logic             last
);
  logic [CNT_W-1:0] step;

  always_comb begin
    step     = CNT_W'(wide) + CNT_W'(1);
    last     = cnt <= step;
    next_cnt = last ? '0 : cnt - step;
  end
endmodule

// File: rtl/rdma_rd_fmt.sv
module rdma_rd_fmt (
  input  logic        clk,
  input  logic        rst,
  input  logic        issue,
  input  logic        wide,
  input  logic        lane,
  input  logic        in_win,
  input  logic [15:0] mem_rdata,
  output logic [15:0] rdata,
  output logic        rvalid
);
  logic v_q, wide_q, lane_q, win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q    <= 1'b0;
      wide_q <= 1'b0;
      lane_q <= 1'b0;
      win_q  <= 1'b0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      v_q    <= issue;
      wide_q <= wide;
      lane_q <= lane;
      win_q  <= in_win;
      rvalid <= v_q;
      if (v_q) begin
        if (!win_q)      rdata <= wide_q ? 16'hFFFF : 16'h00FF;
        else if (wide_q) rdata <= mem_rdata;
        else             rdata <= {8'h00, lane_q ? mem_rdata[15:8] : mem_rdata[7:0]};
      end
    end
  end

  AST_OOW_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    v_q && !win_q |=> rdata[7:0] == 8'hFF); // R8
  AST_NARROW_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    v_q && !wide_q |=> rdata[15:8] == 8'h00); // R3
endmodule

// File: rtl/rdma_port.sv
module rdma_port #(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  parameter int PROM_BYTES = 32,
  parameter int WIN_LO     = 16384,
  parameter int WIN_HI     = 49152
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic [1:0]          reg_sel,
  input  logic [7:0]          reg_wdata,
  input  logic                wide_en,
  input  logic [ADDR_W-9:0]   ring_start_pg,
  input  logic [ADDR_W-9:0]   ring_stop_pg,
  input  logic                cmd_go,
  input  logic                done_clr,
  input  logic                port_wr,
  input  logic                port_rd,
  input  logic [15:0]         port_wdata,
  output logic [15:0]         port_rdata,
  output logic                port_rdata_valid,
  output logic                done_flag,
  output logic [ADDR_W-1:0]   cur_addr,
  output logic [CNT_W-1:0]    remain,
  output logic                mem_en,
  output logic                mem_we,
  output logic [1:0]          mem_be,
  output logic [ADDR_W-2:0]   mem_addr,
  output logic [15:0]         mem_wdata,
  input  logic [15:0]         mem_rdata
);
  import rdma_pkg::*;

  logic              rd_go, wr_go, acc, in_win, last;
  logic [ADDR_W-1:0] eff_addr, next_addr;
  logic [CNT_W-1:0]  next_cnt;
  rdma_reg_e         sel;

  assign sel   = rdma_reg_e'(reg_sel);
  assign rd_go = port_rd;
  assign wr_go = port_wr && !port_rd && (remain != '0);
  assign acc   = rd_go || wr_go;

  rdma_addr_step #(
    .ADDR_W(ADDR_W), .PROM_BYTES(PROM_BYTES), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_addr_step (
    .addr(cur_addr), .wide(wide_en), .start_pg(ring_start_pg), .stop_pg(ring_stop_pg),
    .eff_addr(eff_addr), .next_addr(next_addr), .in_win(in_win)
  );

  rdma_count_step #(.CNT_W(CNT_W)) u_cnt_step (
    .cnt(remain), .wide(wide_en), .next_cnt(next_cnt), .last(last)
  );

  rdma_split_reg #(.W(ADDR_W)) u_addr_reg (
    .clk(clk), .rst(rst),
    .load_lo(reg_we && sel == SEL_ADDR_LO), .load_hi(reg_we && sel == SEL_ADDR_HI),
    .byte_in(reg_wdata), .upd_en(acc), .upd_val(next_addr), .q(cur_addr)
  );

  rdma_split_reg #(.W(CNT_W)) u_cnt_reg (
    .clk(clk), .rst(rst),
    .load_lo(reg_we && sel == SEL_CNT_LO), .load_hi(reg_we && sel == SEL_CNT_HI),
    .byte_in(reg_wdata), .upd_en(acc), .upd_val(next_cnt), .q(remain)
  );

  always_comb begin
    mem_en    = acc && in_win;
    mem_we    = wr_go && in_win;
    mem_addr  = eff_addr[ADDR_W-1:1];
    mem_be    = wide_en ? 2'b11 : (eff_addr[0] ? 2'b10 : 2'b01);
    mem_wdata = wide_en ? port_wdata : {2{port_wdata[7:0]}};
  end

  always_ff @(posedge clk) begin
    if (rst)                                      done_flag <= 1'b0;
    else if ((acc && last) || (cmd_go && remain == '0)) done_flag <= 1'b1;
    else if (done_clr)                            done_flag <= 1'b0;
  end

  rdma_rd_fmt u_rd_fmt (
    .clk(clk), .rst(rst), .issue(rd_go), .wide(wide_en), .lane(eff_addr[0]),
    .in_win(in_win), .mem_rdata(mem_rdata), .rdata(port_rdata), .rvalid(port_rdata_valid)
  );

  AST_LAST_DONE: assert property (@(posedge clk) disable iff (rst)
    acc && last && !reg_we |=> done_flag && remain == '0); // R5
  AST_ZERO_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    port_wr && !port_rd && remain == '0 && !reg_we && !done_flag && !cmd_go
      |=> $stable(cur_addr) && $stable(remain) && !done_flag); // R6
  AST_NOT_AT_STOP: assert property (@(posedge clk) disable iff (rst)
    acc && !reg_we && ring_start_pg != ring_stop_pg
      |=> cur_addr != {$past(ring_stop_pg), 8'h00}); // R4
  AST_CMD_ZERO_DONE: assert property (@(posedge clk) disable iff (rst)
    cmd_go && remain == '0 |=> done_flag); // R9
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    port_rd |-> ##2 port_rdata_valid); // R11
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done_flag && !done_clr |=> done_flag); // R10
endmodule

// File: tb/rdma_port_bench.sv
module rdma_port_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we = 0;
  logic [1:0]  reg_sel = 0;
  logic [7:0]  reg_wdata = 0;
  logic        wide_en = 0;
  logic [7:0]  ring_start_pg = 8'h40;
  logic [7:0]  ring_stop_pg  = 8'h42;
  logic        cmd_go = 0, done_clr = 0, port_wr = 0, port_rd = 0;
  logic [15:0] port_wdata = 0;
  logic [15:0] port_rdata;
  logic        port_rdata_valid, done_flag;
  logic [15:0] cur_addr, remain;
  logic        mem_en, mem_we;
  logic [1:0]  mem_be;
  logic [14:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = 0;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] m_addr, m_cnt;
  logic        m_done, m_wide;
  logic [15:0] tbmem [int unsigned];
  logic [7:0]  refb  [int unsigned];

  always #10 clk = ~clk;

  rdma_port u_rdma_port (.*);

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [15:0] dflt_word(input logic [14:0] w);
    return {pat({w, 1'b1}), pat({w, 1'b0})};
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      logic [15:0] w;
      w = tbmem.exists(int'(mem_addr)) ? tbmem[int'(mem_addr)] : dflt_word(mem_addr);
      if (mem_we) begin
        if (mem_be[0]) w[7:0]  = mem_wdata[7:0];
        if (mem_be[1]) w[15:8] = mem_wdata[15:8];
        tbmem[int'(mem_addr)] = w;
      end else begin
        mem_rdata <= w;
      end
    end
  end

  function automatic logic [7:0] getb(input logic [15:0] a);
    return refb.exists(int'(a)) ? refb[int'(a)] : pat(a);
  endfunction

  function automatic bit win(input logic [15:0] a);
    return (a < 16'd32) || (a >= 16'd16384 && a < 16'd49152);
  endfunction

  function automatic logic [15:0] m_eff();
    return m_wide ? {m_addr[15:1], 1'b0} : m_addr;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " addr"}, 32'(cur_addr), 32'(m_addr));
    chk({tag, " count"}, 32'(remain), 32'(m_cnt));
    chk({tag, " done"}, 32'(done_flag), 32'(m_done));
  endtask

  task automatic mdl_advance();
    logic [15:0] st;
    st = m_wide ? 16'd2 : 16'd1;
    m_addr = m_addr + st;
    if (m_addr == {ring_stop_pg, 8'h00}) m_addr = {ring_start_pg, 8'h00};
    if (m_cnt <= st) begin m_cnt = 0; m_done = 1; end
    else m_cnt = m_cnt - st;
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] v);
    reg_we = 1; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_we = 0;
    case (sel)
      2'd0: m_addr[7:0]  = v;
      2'd1: m_addr[15:8] = v;
      2'd2: m_cnt[7:0]   = v;
      default: m_cnt[15:8] = v;
    endcase
  endtask

  task automatic set_addr(input logic [15:0] v);
    wr_reg(2'd0, v[7:0]); wr_reg(2'd1, v[15:8]);
  endtask

  task automatic set_cnt(input logic [15:0] v);
    wr_reg(2'd2, v[7:0]); wr_reg(2'd3, v[15:8]);
  endtask

  task automatic set_wide(input logic b);
    wide_en = b; m_wide = b;
  endtask

  task automatic op_rd(input string tag);
    logic [15:0] e, exp;
    e = m_eff();
    if (!win(e))     exp = m_wide ? 16'hFFFF : 16'h00FF;
    else if (m_wide) exp = {getb(e + 16'd1), getb(e)};
    else             exp = {8'h00, getb(e)};
    port_rd = 1;
    @(negedge clk);
    port_rd = 0;
    mdl_advance();
    chk_state(tag);
    chk({tag, " R11 early valid"}, 32'(port_rdata_valid), 0);
    @(negedge clk);
    chk({tag, " R11 valid"}, 32'(port_rdata_valid), 1);
    chk({tag, " data"}, 32'(port_rdata), 32'(exp));
  endtask

  task automatic op_wr(input string tag, input logic [15:0] d);
    logic [15:0] e;
    e = m_eff();
    port_wr = 1; port_wdata = d;
    @(negedge clk);
    port_wr = 0;
    if (m_cnt != 0) begin
      if (win(e)) begin
        refb[int'(e)] = d[7:0];
        if (m_wide) refb[int'(e + 16'd1)] = d[15:8];
      end
      mdl_advance();
    end
    chk_state(tag);
  endtask

  task automatic op_cmd(input string tag);
    cmd_go = 1;
    @(negedge clk);
    cmd_go = 0;
    if (m_cnt == 0) m_done = 1;
    chk_state(tag);
  endtask

  task automatic op_clr(input string tag);
    done_clr = 1;
    @(negedge clk);
    done_clr = 0;
    m_done = 0;
    chk_state(tag);
  endtask

  function automatic logic [15:0] pick_addr();
    case ($urandom % 5)
      0: return 16'h41F8 + 16'($urandom % 8);
      1: return 16'h0018 + 16'($urandom % 16);
      2: return 16'h3FFC + 16'($urandom % 8);
      3: return 16'hBFFC + 16'($urandom % 8);
      default: return 16'h4000 + 16'($urandom % 512);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog expired got %h exp %h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    m_addr = 0; m_cnt = 0; m_done = 0; m_wide = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk_state("R1 reset");
    chk("R1 rvalid", 32'(port_rdata_valid), 0);

    // R2 byte loads
    set_addr(16'h1234);
    chk("R2 addr full", 32'(cur_addr), 32'h1234);
    wr_reg(2'd0, 8'h78);
    chk("R2 addr hi kept", 32'(cur_addr), 32'h1278);
    set_cnt(16'hA5C3);
    wr_reg(2'd3, 8'h01);
    chk("R2 count lo kept", 32'(remain), 32'h01C3);

    // R3 lanes: two narrow writes then wide read
    set_wide(0);
    set_addr(16'h0004); set_cnt(16'd2);
    op_wr("R3 narrow wr0", 16'h00AB);
    op_wr("R3 narrow wr1 R5", 16'h00CD);
    set_wide(1);
    set_addr(16'h0004); set_cnt(16'd2);
    op_rd("R3 wide rd");
    chk("R3 wide value", 32'(port_rdata), 32'hCDAB);
    set_addr(16'h0005); set_cnt(16'd4);
    op_rd("R3 odd wide rd");
    chk("R3 odd addr", 32'(cur_addr), 32'h0007);
    set_wide(0);
    set_addr(16'h0005);
    op_rd("R3 narrow rd hi lane");
    chk("R3 narrow value", 32'(port_rdata), 32'h00CD);

    // R6 write at zero count
    op_clr("R10 clear");
    set_addr(16'h0008); set_cnt(16'd0);
    op_wr("R6 zero write", 16'h0099);
    chk("R6 done stays", 32'(done_flag), 0);
    // R7 read at zero count returns old data and completes
    op_rd("R7 zero read");
    chk("R7 done", 32'(done_flag), 1);

    // R8 out-of-window
    set_addr(16'h2000); set_cnt(16'd4);
    op_wr("R8 oow wr", 16'h0011);
    set_addr(16'h2000);
    op_rd("R8 oow narrow rd");
    chk("R8 narrow ones", 32'(port_rdata), 32'h00FF);
    set_wide(1);
    op_rd("R8 oow wide rd");
    chk("R8 wide ones", 32'(port_rdata), 32'hFFFF);
    set_addr(16'hBFFE); set_cnt(16'd4);
    op_rd("R8 last in window");

    // R4 wrap
    set_addr(16'h41FE); set_cnt(16'd10);
    op_wr("R4 wrap wr", 16'hBEEF);
    chk("R4 wrapped", 32'(cur_addr), 32'h4000);
    set_addr(16'h41FF);
    op_rd("R4 no wrap odd");
    chk("R4 passed stop", 32'(cur_addr), 32'h4201);

    // R9 command
    op_clr("R10 clear2");
    set_cnt(16'd0);
    op_cmd("R9 cmd zero");
    op_clr("R10 clear3");
    set_cnt(16'd5);
    op_cmd("R9 cmd nonzero");

    // R10 set wins over clear
    set_wide(0); set_addr(16'h4010); set_cnt(16'd1);
    port_wr = 1; port_wdata = 16'h0042; done_clr = 1;
    @(negedge clk);
    port_wr = 0; done_clr = 0;
    refb[int'(16'h4010)] = 8'h42;
    mdl_advance();
    chk_state("R10 set beats clear");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom % 16;
      if (r < 2)       set_addr(pick_addr());
      else if (r == 2) set_cnt(($urandom % 8 == 0) ? 16'($urandom % 300) : 16'($urandom % 6));
      else if (r == 3) set_wide(1'($urandom % 2));
      else if (r < 9)  op_rd("R3/R4/R5/R8 rand rd");
      else if (r < 14) op_wr("R4/R5/R6 rand wr", 16'($urandom));
      else if (r == 14) op_cmd("R9 rand cmd");
      else              op_clr("R10 rand clr");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule